// File: doc/BRIEF.md
# Logarithmic Shift and Rotate Unit

This block is a purely combinational shifter that moves a data word left or right by a variable number of positions. It is built as a chain of two-way multiplexer stages. Stage k either passes its input unchanged or moves it by 2^k places, and bit k of the shift amount makes that choice. A WIDTH-bit word therefore needs only log2(WIDTH) stages, and every amount from 0 to WIDTH-1 takes the same logic depth.

One network serves five operations. They differ only in what fills the vacated positions at each stage: zeros, copies of the original sign bit, or the bits that were pushed out of the opposite end. An operation code sets the direction and the fill source. Codes outside the five defined ones leave the word unchanged.

The unit sits in an execution datapath next to an adder. The caller drives the word, the amount and the operation code, and reads the result in the same cycle.

Top module: `log_shift_rotate`

## Requirements
- R1: With op_sel = 3'b000 (logical left shift), data_out equals data_in multiplied by 2^shamt, truncated to WIDTH bits, so the shamt lowest bits are zero.
- R2: With op_sel = 3'b001 (logical right shift), data_out equals data_in divided by 2^shamt (unsigned, rounded down), so the shamt highest bits are zero.
- R3: With op_sel = 3'b010 (arithmetic right shift), data_out is data_in read as two's complement, divided by 2^shamt and rounded toward minus infinity, so the shamt highest bits equal the original data_in[WIDTH-1].
- R4: With op_sel = 3'b011 (rotate left), bits leaving the most significant end re-enter at the least significant end: data_out[(i+shamt) mod WIDTH] = data_in[i].
- R5: With op_sel = 3'b100 (rotate right), bits leaving the least significant end re-enter at the most significant end: data_out[i] = data_in[(i+shamt) mod WIDTH].
- R6: With op_sel equal to 3'b101, 3'b110 or 3'b111, data_out equals data_in for every shift amount.
- R7: A shift amount of zero returns data_in unchanged on data_out for every operation code.
- R8: The output is combinational. It holds no state, and a new data_out follows a change of any input without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be shifted or rotated |
| shamt | input | log2(WIDTH) | Number of positions to move; bit k drives stage k |
| op_sel | input | 3 | Operation code: 000 left logical, 001 right logical, 010 right arithmetic, 011 rotate left, 100 rotate right, others pass through |
| data_out | output | WIDTH | Shifted or rotated result |

## Verification
Assertions check, for every input that reaches the block, that the vacated positions hold the right fill for each shift kind. Rotations must keep the count of set bits. The undefined codes and a zero amount must leave the word untouched. Inside each stage, a wrapping move must not lose or create set bits. These properties do not pin down where each surviving bit lands, so the exact bit positions are shown only by the bench. The bench sweeps every word, amount and code at width 8 and compares each result with a value computed by multiplication, division and modulo. A separate scenario changes the inputs with no clock edge and shows that the output follows at once.

// File: rtl/log_shift_pkg.sv
package log_shift_pkg;

  typedef enum logic [2:0] {
    OP_SLL = 3'b000,
    OP_SRL = 3'b001,
    OP_SRA = 3'b010,
    OP_ROL = 3'b011,
    OP_ROR = 3'b100
  } shift_op_e;

  // Per-stage control shared by every mux stage
  typedef struct packed {
    logic active;   // stage may move data at all
    logic to_left;  // direction of movement
    logic wrap;     // fill from the opposite end
    logic sign_ext; // fill with the original sign bit
  } stage_ctrl_t;

  function automatic stage_ctrl_t decode_shift_op(input logic [2:0] code);
    stage_ctrl_t c;
    c = '0;
    case (code)
      OP_SLL: begin c.active = 1'b1; c.to_left = 1'b1; end
      OP_SRL: begin c.active = 1'b1; end
      OP_SRA: begin c.active = 1'b1; c.sign_ext = 1'b1; end
      OP_ROL: begin c.active = 1'b1; c.to_left = 1'b1; c.wrap = 1'b1; end
      OP_ROR: begin c.active = 1'b1; c.wrap = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/shift_op_decode.sv
module shift_op_decode
  import log_shift_pkg::*;
(
  input  logic [2:0]  op_sel,
  output stage_ctrl_t ctrl
);

  always_comb begin
    ctrl = decode_shift_op(op_sel);
  end

  always_comb begin
    // R3
    sra_exclusive_chk: assert (!(ctrl.sign_ext && (ctrl.to_left || ctrl.wrap)))
      else $error("sign fill combined with left or wrap");
    // R6
    undefined_idle_chk: assert (!(op_sel > 3'b100) || !ctrl.active)
      else $error("undefined code enabled a stage");
  end

endmodule

// File: rtl/shift_mux_stage.sv
module shift_mux_stage
  import log_shift_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] stage_in,
  input  logic             move_sel,
  input  stage_ctrl_t      ctrl,
  input  logic             sign_bit,
  output logic [WIDTH-1:0] stage_out
);

  logic [DIST-1:0]  fill_low;
  logic [DIST-1:0]  fill_high;
  logic [WIDTH-1:0] moved_left;
  logic [WIDTH-1:0] moved_right;
  logic             take_move;

  always_comb begin
    fill_low  = ctrl.wrap ? stage_in[WIDTH-1 -: DIST] : '0;
    if (ctrl.wrap)          fill_high = stage_in[DIST-1:0];
    else if (ctrl.sign_ext) fill_high = {DIST{sign_bit}};
    else                    fill_high = '0;
    moved_left  = {stage_in[WIDTH-1-DIST:0], fill_low};
    moved_right = {fill_high, stage_in[WIDTH-1:DIST]};
    take_move   = move_sel & ctrl.active;
    stage_out   = take_move ? (ctrl.to_left ? moved_left : moved_right) : stage_in;
  end

  always_comb begin
    // R4 R5
    stage_wrap_count_chk: assert (!(take_move && ctrl.wrap) ||
                                  ($countones(stage_out) == $countones(stage_in)))
      else $error("wrapping stage changed bit count");
  end

endmodule

// File: rtl/log_shift_rotate.sv
module log_shift_rotate
  import log_shift_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] shamt,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] data_out
);

  stage_ctrl_t                ctrl;
  logic [AMT_W:0][WIDTH-1:0]  chain;
  logic                       orig_sign;

  assign orig_sign = data_in[WIDTH-1];
  assign chain[0]  = data_in;

  shift_op_decode u_decode (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shift_mux_stage #(
      .WIDTH (WIDTH),
      .DIST  (2 ** k)
    ) u_stage (
      .stage_in  (chain[k]),
      .move_sel  (shamt[k]),
      .ctrl      (ctrl),
      .sign_bit  (orig_sign),
      .stage_out (chain[k+1])
    );
  end

  assign data_out = chain[AMT_W];

  // Masks of the lowest / highest n bit positions
  function automatic logic [WIDTH-1:0] low_ones(input logic [AMT_W-1:0] n);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < WIDTH; i++) if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [WIDTH-1:0] high_ones(input logic [AMT_W-1:0] n);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < WIDTH; i++) if (i >= WIDTH - int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  always_comb begin
    if (op_sel == OP_SLL) begin
      // R1
      sll_fill_chk: assert ((data_out & low_ones(shamt)) == '0)
        else $error("left shift fill not zero");
    end
    if (op_sel == OP_SRL) begin
      // R2
      srl_fill_chk: assert ((data_out & high_ones(shamt)) == '0)
        else $error("right shift fill not zero");
    end
    if (op_sel == OP_SRA) begin
      // R3
      sra_fill_chk: assert ((data_out & high_ones(shamt)) ==
                            (data_in[WIDTH-1] ? high_ones(shamt) : '0))
        else $error("arithmetic fill not sign");
    end
    if (op_sel == OP_ROL || op_sel == OP_ROR) begin
      // R4 R5
      rot_popcount_chk: assert ($countones(data_out) == $countones(data_in))
        else $error("rotate changed bit count");
    end
    if (op_sel > 3'b100) begin
      // R6
      passthru_chk: assert (data_out == data_in)
        else $error("undefined code altered data");
    end
    if (shamt == '0) begin
      // R7
      zero_amt_chk: assert (data_out == data_in)
        else $error("zero amount altered data");
    end
  end

endmodule

// File: tb/log_shift_rotate_tb.sv
module log_shift_rotate_tb_top;

  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  data_in;
  logic [AW-1:0] shamt;
  logic [2:0]    op_sel;
  logic [W-1:0]  data_out;

  int n_checks;
  int n_fail;
  bit finished;

  log_shift_rotate #(.WIDTH(W)) dut_i (
    .data_in  (data_in),
    .shamt    (shamt),
    .op_sel   (op_sel),
    .data_out (data_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int model(input int d, input int a, input int op);
    int p, v, q;
    p = 1 << a;
    case (op)
      0: return (d * p) % 256;
      1: return d / p;
      2: begin
        v = (d >= 128) ? d - 256 : d;
        q = (v >= 0) ? v / p : -((-v + p - 1) / p);
        return (q + 256) % 256;
      end
      3: return ((d * p) % 256) + d / (256 / p);
      4: return d / p + (d % p) * (256 / p);
      default: return d;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: data=%0d amt=%0d op=%0d actual=%0d expected=%0d",
               req, data_in, shamt, op_sel, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 0;
    rst_n    = 1'b0;
    data_in  = '0;
    shamt    = '0;
    op_sel   = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", int'(data_out), 0);

    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 8; a++) begin
        for (int d = 0; d < 256; d++) begin
          @(posedge clk);
          data_in = W'(d);
          shamt   = AW'(a);
          op_sel  = 3'(op);
          @(negedge clk);
          if (a == 0)      check("R7", int'(data_out), d);
          else if (op > 4) check("R6", int'(data_out), d);
          else case (op)
            0: check("R1", int'(data_out), model(d, a, op));
            1: check("R2", int'(data_out), model(d, a, op));
            2: check("R3", int'(data_out), model(d, a, op));
            3: check("R4", int'(data_out), model(d, a, op));
            default: check("R5", int'(data_out), model(d, a, op));
          endcase
        end
      end
    end

    // R8: output follows inputs between clock edges
    @(negedge clk);
    data_in = 8'hB4; shamt = 3'd3; op_sel = 3'b010;
    #1 check("R8", int'(data_out), model(8'hB4, 3, 2));
    data_in = 8'h81; shamt = 3'd1; op_sel = 3'b100;
    #1 check("R8", int'(data_out), model(8'h81, 1, 4));

    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

endmodule